// File: doc/BRIEF.md
# Virtual-8086 Return Frame Loader

This block completes the last stage of a 32-bit interrupt return that lands in virtual-8086 mode. The caller has already popped the instruction pointer, the code selector and the flags image. It hands them over with a one-cycle start strobe, along with the current stack pointer and the stack segment's default-size bit. The block then fetches the rest of the return frame through a request/acknowledge read port. The frame holds the new 32-bit stack pointer and the stack, extra, data, F and G selectors.

When the last read is acknowledged, the block commits everything in a single clock. That includes the instruction pointer, the stack pointer, the flags and all six selectors. Each segment's hidden descriptor cache is rebuilt the way a real-mode segment looks: the base is the selector times sixteen, the limit is 64 KiB, and the attributes are fixed for a ring-3 read/write data segment. Privilege checks, paging and faults belong to the surrounding core.

Top module: `v86_frame_loader`

## Requirements
- R1: The frame origin is the full `cur_esp` when `ss_big` is 1, and `{16'h0, cur_esp[15:0]}` when it is 0. Each read address is origin + 12 + 4*k for k = 0..5. The sum wraps modulo 2^32 in the wide case and modulo 2^16 in the narrow case, and in the narrow case `mem_addr[31:16]` is zero.
- R2: The six reads go out one at a time in increasing k order, with `mem_req` high. `mem_addr` is held until `mem_ack` is seen, and only then does the next address appear.
- R3: `eip_o` takes the low 16 bits of `in_ip`, and bits 31:16 are zero whatever the input held.
- R4: `esp_o` takes all 32 bits of the word read at k = 0.
- R5: Slot i of `seg_sel_o` is bits `[16*i +: 16]`, with slot order 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. CS comes from `in_cs`. SS, ES, DS, FS and GS come from the low 16 bits of the words read at k = 1, 2, 3, 4, 5 respectively.
- R6: For every slot i, the cache fields are set as follows. The base `seg_base_o[32*i +: 32]` equals `{12'h0, sel, 4'h0}` and the limit `seg_limit_o[32*i +: 32]` equals 32'h0000FFFF. The attribute field `seg_attr_o[13*i +: 13]` equals 13'b1_11_1_0011_000_11, packed as {present, dpl[1:0], code/data, type[3:0], gran, default-size, avl, rpl[1:0]}.
- R7: `eflags_o` equals `(in_flags & 32'h003F7FD5) | 32'h2`. This means IOPL, IF, VM, RF and the other architectural bits take the supplied values, and reserved bits read as in reset.
- R8: `done` is high for exactly one cycle, and that is the first cycle in which the new values appear on every output. `busy` is high from the cycle after start until that cycle.
- R9: While `busy` is high, all result outputs keep their previous values, and a `start` pulse is ignored.
- R10: After reset, `busy`, `done` and `mem_req` are 0, `eflags_o` is 32'h2, and every other result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame load (ignored when busy) |
| in_ip | input | 32 | Popped instruction pointer |
| in_cs | input | 16 | Popped code selector |
| in_flags | input | 32 | Popped flags image |
| cur_esp | input | 32 | Stack pointer at frame base |
| ss_big | input | 1 | Stack segment default-size bit |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address (stack offset) |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| eip_o | output | 32 | Loaded instruction pointer |
| esp_o | output | 32 | Loaded stack pointer |
| eflags_o | output | 32 | Loaded flags |
| seg_sel_o | output | 96 | Six selectors, 16 bits each |
| seg_base_o | output | 192 | Six cache bases |
| seg_limit_o | output | 192 | Six cache limits |
| seg_attr_o | output | 78 | Six 13-bit attribute fields |

## Verification
The bench places the narrow stack pointer just below 64 KiB so that frame addresses roll over to zero. A design that carried into bit 16 would fetch from the wrong place, and one that leaked stale upper stack-pointer bits would too. The bench also wraps the wide pointer at 4 GiB. Instruction pointers with busy upper halves and read words with non-zero upper halves expose a design that forgets to truncate the IP or the selectors, or one that clips the stack pointer. A second start during a load, and slow random acknowledges, catch a sequencer that restarts, skips a read, or shows results before the final commit.

// File: rtl/v86_frame_loader.sv
module v86_frame_loader #(
  parameter logic [31:0] FLAG_MASK = 32'h003F_7FD5,
  parameter int          NSEG      = 6,
  parameter int          NRD       = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [31:0]          in_ip,
  input  logic [15:0]          in_cs,
  input  logic [31:0]          in_flags,
  input  logic [31:0]          cur_esp,
  input  logic                 ss_big,
  output logic                 mem_req,
  output logic [31:0]          mem_addr,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata,
  output logic                 busy,
  output logic                 done,
  output logic [31:0]          eip_o,
  output logic [31:0]          esp_o,
  output logic [31:0]          eflags_o,
  output logic [NSEG*16-1:0]   seg_sel_o,
  output logic [NSEG*32-1:0]   seg_base_o,
  output logic [NSEG*32-1:0]   seg_limit_o,
  output logic [NSEG*13-1:0]   seg_attr_o
);
  localparam int          IW    = $clog2(NRD);
  localparam logic [IW-1:0] LAST = IW'(NRD - 1);
  localparam logic [12:0] ATTR  = {1'b1, 2'd3, 1'b1, 4'b0011, 3'b000, 2'd3};

  logic [IW-1:0] idx;
  logic [31:0]   base_q;
  logic          big_q;
  logic [15:0]   ip_q, cs_q;
  logic [31:0]   fl_q;
  logic [31:0]   rd_q [NRD-1];
  logic [31:0]   off, sum;
  logic [15:0]   nsel [NSEG];
  logic          last_ack;

  assign mem_req  = busy;
  assign off      = 32'd12 + {{(30-IW){1'b0}}, idx, 2'b00};
  assign sum      = base_q + off;
  assign mem_addr = big_q ? sum : {16'h0, sum[15:0]};
  assign last_ack = busy && mem_ack && (idx == LAST);

  assign nsel[0] = rd_q[2][15:0];
  assign nsel[1] = cs_q;
  assign nsel[2] = rd_q[1][15:0];
  assign nsel[3] = rd_q[3][15:0];
  assign nsel[4] = rd_q[4][15:0];
  assign nsel[5] = mem_rdata[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      base_q <= '0;
      big_q  <= 1'b0;
      ip_q   <= '0;
      cs_q   <= '0;
      fl_q   <= '0;
      for (int k = 0; k < NRD-1; k++) rd_q[k] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          idx    <= '0;
          big_q  <= ss_big;
          base_q <= ss_big ? cur_esp : {16'h0, cur_esp[15:0]};
          ip_q   <= in_ip[15:0];
          cs_q   <= in_cs;
          fl_q   <= in_flags;
        end
      end else if (mem_ack) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rd_q[idx[$clog2(NRD-1)-1:0]] <= mem_rdata;
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eip_o       <= '0;
      esp_o       <= '0;
      eflags_o    <= 32'h2;
      seg_sel_o   <= '0;
      seg_base_o  <= '0;
      seg_limit_o <= '0;
      seg_attr_o  <= '0;
    end else if (last_ack) begin
      eip_o    <= {16'h0, ip_q};
      esp_o    <= rd_q[0];
      eflags_o <= (fl_q & FLAG_MASK) | 32'h2;
      for (int s = 0; s < NSEG; s++) begin
        seg_sel_o[16*s +: 16]   <= nsel[s];
        seg_base_o[32*s +: 32]  <= {12'h0, nsel[s], 4'h0};
        seg_limit_o[32*s +: 32] <= 32'h0000_FFFF;
        seg_attr_o[13*s +: 13]  <= ATTR;
      end
    end
  end

  p_wrap_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !big_q) |-> (mem_addr[31:16] == 16'h0));

  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_ip_trunc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (eip_o[31:16] == 16'h0));

  p_cache_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seg_base_o[32*2 +: 32] == {12'h0, seg_sel_o[16*2 +: 16], 4'h0}));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(eip_o) && $stable(esp_o) && $stable(seg_sel_o))));
endmodule

// File: tb/v86_frame_loader_bench.sv
`timescale 1ns/1ps
module v86_frame_loader_bench;
  logic clk = 0, rst_n = 0, start = 0, ss_big = 0, mem_ack = 0;
  logic [31:0] in_ip = 0, in_flags = 0, cur_esp = 0, mem_rdata = 0;
  logic [15:0] in_cs = 0;
  logic mem_req, busy, done;
  logic [31:0] mem_addr, eip_o, esp_o, eflags_o;
  logic [95:0] seg_sel_o;
  logic [191:0] seg_base_o, seg_limit_o;
  logic [77:0] seg_attr_o;

  int nchk = 0, nerr = 0, rd_k = 0;
  logic [31:0] t_esp;
  logic t_big;

  always #10 clk = ~clk;

  v86_frame_loader u_v86_frame_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ip(in_ip), .in_cs(in_cs),
    .in_flags(in_flags), .cur_esp(cur_esp), .ss_big(ss_big),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .eip_o(eip_o), .esp_o(esp_o), .eflags_o(eflags_o),
    .seg_sel_o(seg_sel_o), .seg_base_o(seg_base_o), .seg_limit_o(seg_limit_o),
    .seg_attr_o(seg_attr_o));

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] exp_addr(input logic big, input logic [31:0] sp, input int k);
    logic [15:0] lo;
    if (big) return sp + 32'(12 + 4*k);
    lo = sp[15:0] + 16'(12 + 4*k);
    return {16'h0, lo};
  endfunction

  task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : responder
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req && $urandom_range(0, 2) != 0) begin
        check(rd_k == 0 ? "R1 addr" : "R2 order", 192'(mem_addr), 192'(exp_addr(t_big, t_esp, rd_k)));
        mem_rdata = memf(mem_addr);
        mem_ack = 1;
        rd_k++;
      end
    end
  end

  task automatic run(input logic [31:0] ip, input logic [15:0] cs, input logic [31:0] fl,
                     input logic [31:0] sp, input logic big, input bit poke);
    logic [31:0] s_eip, s_esp;
    logic [95:0] s_sel;
    logic [15:0] es;
    logic [15:0] sel [6];
    bit moved = 0;
    int cyc = 0;
    s_eip = eip_o; s_esp = esp_o; s_sel = seg_sel_o;
    t_esp = sp; t_big = big; rd_k = 0;
    @(negedge clk);
    in_ip = ip; in_cs = cs; in_flags = fl; cur_esp = sp; ss_big = big; start = 1;
    @(negedge clk);
    start = 0;
    in_ip = ~ip; in_cs = ~cs; cur_esp = sp + 32'h100;
    while (!done && cyc < 300) begin
      if (busy && (eip_o !== s_eip || esp_o !== s_esp || seg_sel_o !== s_sel)) moved = 1;
      if (poke && cyc == 3) start = 1;
      if (poke && cyc == 4) start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    check("R9 hold while busy", 192'(moved), 192'(0));
    check("R8 done reached", 192'(done), 192'(1));
    check("R2 six reads", 192'(rd_k), 192'(6));
    sel[1] = cs;
    sel[2] = memf(exp_addr(big, sp, 1))[15:0];
    sel[0] = memf(exp_addr(big, sp, 2))[15:0];
    sel[3] = memf(exp_addr(big, sp, 3))[15:0];
    sel[4] = memf(exp_addr(big, sp, 4))[15:0];
    sel[5] = memf(exp_addr(big, sp, 5))[15:0];
    check("R3 eip", 192'(eip_o), 192'({16'h0, ip[15:0]}));
    check("R4 esp", 192'(esp_o), 192'(memf(exp_addr(big, sp, 0))));
    check("R7 eflags", 192'(eflags_o), 192'((fl & 32'h003F7FD5) | 32'h2));
    for (int s = 0; s < 6; s++) begin
      es = sel[s];
      check("R5 selector", 192'(seg_sel_o[16*s +: 16]), 192'(es));
      check("R6 base", 192'(seg_base_o[32*s +: 32]), 192'({12'h0, es, 4'h0}));
      check("R6 limit", 192'(seg_limit_o[32*s +: 32]), 192'(32'hFFFF));
      check("R6 attr", 192'(seg_attr_o[13*s +: 13]), 192'(13'b1_11_1_0011_000_11));
    end
    @(negedge clk);
    check("R8 done one cycle", 192'(done), 192'(0));
    check("R9 no restart", 192'(busy), 192'(0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 busy", 192'(busy), 192'(0));
    check("R10 done", 192'(done), 192'(0));
    check("R10 req", 192'(mem_req), 192'(0));
    check("R10 eflags", 192'(eflags_o), 192'(32'h2));
    check("R10 eip", 192'(eip_o), 192'(0));
    check("R10 sel", 192'(seg_sel_o), 192'(0));
    check("R10 base", seg_base_o, 192'(0));
    run(32'hDEAD_1234, 16'h1000, 32'hFFFF_FFFF, 32'hABCD_FFF0, 1'b0, 1'b0);
    run(32'h0001_FFFF, 16'hF000, 32'h0002_3202, 32'hFFFF_FFF0, 1'b1, 1'b0);
    run(32'h8000_0000, 16'h0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1);
    run(32'h1234_5678, 16'h2222, 32'h0003_B2D7, 32'h0000_8000, 1'b1, 1'b1);
    for (int n = 0; n < 40; n++)
      run($urandom, 16'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom_range(0, 3) == 0));
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule